// File: doc/BRIEF.md
# Carry-Free Signed-Digit Radix-4 Adder

This block adds two words of radix-4 signed digits. Every digit lies in -3..3, so the same integer can be written in more than one way. A carry therefore never has to travel the length of the word. The adder works in two local steps at each digit position. First it splits the sum of the two operand digits into an interim digit and a transfer digit in -1..+1. Then it adds each interim digit to the transfer coming from the position below. The delay is that of one digit pair plus one neighbour, whatever the word length.

The word length `M` is a parameter. The result has `M+1` digits and uses the same 3-bit digit code as the operands. A parameter selects either a purely combinational path or an output register with a clock enable. The block is meant to sit inside a signed-digit arithmetic datapath, where results stay redundant until a later stage converts them.

Top module: `rr4_cfadd`

## Requirements
- R1: Digit i of a word occupies bits [3i+2:3i]. Bit 3i+2 is the sign (1 = negative) and bits [3i+1:3i] hold the magnitude, so the codes are 000=0, 001=1, 010=2, 011=3, 101=-1, 110=-2, 111=-3.
- R2: The value of `sum_o`, taken as the sum of d_i·4^i, equals the value of `a_i` plus the value of `b_i`.
- R3: No digit of `sum_o` ever carries the code 100.
- R4: An operand digit coded 100 is taken as zero, and the result is then identical to the result with that digit coded 000.
- R5: The top result digit (index M) is the transfer out of position M-1 and is always -1, 0 or +1.
- R6: Result digit i depends only on operand positions i and i-1. Changing operand position j leaves every result digit other than j and j+1 unchanged.
- R7: With REGISTER_OUT=1, `sum_o` takes the new result on a rising clock edge where `en` is 1, so it is valid one cycle after the operands. When `en` is 0, `sum_o` holds its value.
- R8: While `rst_n` is low, `sum_o` is all zeros.
- R9: Let the position sum be p. If p ≥ 3 the transfer is +1 and the interim digit is p-4. If p ≤ -3 the transfer is -1 and the interim digit is p+4. Otherwise the transfer is 0 and the interim digit is p. So all +3 plus all +3 gives [1 3 … 3 2], and all -3 plus all -3 gives [-1 -3 … -3 -2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable of the output register |
| a_i | input | 3*M | First operand, M signed digits |
| b_i | input | 3*M | Second operand, M signed digits |
| sum_o | output | 3*(M+1) | Result, M+1 signed digits |

## Verification
At a single position, the outgoing transfer and the incoming transfer are resolved in the same evaluation. The worst case is a position that emits a transfer and also absorbs one from below, which drives the final digit to exactly ±3. The bench provokes this with words of all +3 plus all +3 and all -3 plus all -3, where every position both produces and receives a transfer. It judges the result digit by digit against the exact strings of R9, and also by integer value.

// File: rtl/rr4_pkg.sv
package rr4_pkg;

  typedef logic [2:0] rr4_code_t;

  // signed digit code -> integer value (negative zero reads as zero)
  function automatic logic signed [3:0] rr4_dec(input rr4_code_t c);
    logic signed [3:0] m;
    m = {2'b00, c[1:0]};
    rr4_dec = c[2] ? -m : m;
  endfunction

  // integer value in -3..3 -> code, never producing 100
  function automatic rr4_code_t rr4_enc(input logic signed [3:0] v);
    logic signed [3:0] n;
    n = -v;
    if (v < 4'sd0) rr4_enc = {1'b1, n[1:0]};
    else           rr4_enc = {1'b0, v[1:0]};
  endfunction

endpackage

// File: rtl/rr4_split.sv
// Step one at one position: interim digit and transfer.
module rr4_split
  import rr4_pkg::*;
(
  input  rr4_code_t         x_i,
  input  rr4_code_t         y_i,
  output logic signed [2:0] mid_o,
  output logic signed [1:0] xfer_o
);
  logic signed [3:0] psum;
  logic signed [3:0] adj;

  always_comb begin
    psum = rr4_dec(x_i) + rr4_dec(y_i);
    if (psum >= 4'sd3) begin
      adj    = psum - 4'sd4;
      xfer_o = 2'sb01;
    end else if (psum <= -4'sd3) begin
      adj    = psum + 4'sd4;
      xfer_o = 2'sb11;
    end else begin
      adj    = psum;
      xfer_o = 2'sb00;
    end
    mid_o = adj[2:0];
  end
endmodule

// File: rtl/rr4_merge.sv
// Step two at one position: interim digit plus incoming transfer.
module rr4_merge
  import rr4_pkg::*;
(
  input  logic signed [2:0] mid_i,
  input  logic signed [1:0] xfer_i,
  output rr4_code_t         dig_o
);
  logic signed [3:0] tot;

  always_comb begin
    tot   = {mid_i[2], mid_i} + {{2{xfer_i[1]}}, xfer_i};
    dig_o = rr4_enc(tot);
  end
endmodule

// File: rtl/rr4_out_reg.sv
module rr4_out_reg #(
  parameter int W = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_o;
    if (en) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_nxt;
  end
endmodule

// File: rtl/rr4_cfadd.sv
module rr4_cfadd
  import rr4_pkg::*;
#(
  parameter int M            = 8,
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [3*M-1:0]     a_i,
  input  logic [3*M-1:0]     b_i,
  output logic [3*(M+1)-1:0] sum_o
);
  localparam int OW = 3 * (M + 1);

  logic signed [2:0] mid  [M];
  logic signed [1:0] xfer [M+1];
  logic [OW-1:0]     sum_c;

  assign xfer[0] = 2'sb00;

  for (genvar i = 0; i < M; i++) begin : g_pos
    rr4_split u_split (
      .x_i   (a_i[3*i +: 3]),
      .y_i   (b_i[3*i +: 3]),
      .mid_o (mid[i]),
      .xfer_o(xfer[i+1])
    );
    rr4_merge u_merge (
      .mid_i (mid[i]),
      .xfer_i(xfer[i]),
      .dig_o (sum_c[3*i +: 3])
    );
  end

  // top digit: transfer out of the highest position
  assign sum_c[3*M +: 3] = rr4_enc({{2{xfer[M][1]}}, xfer[M]});

  if (REGISTER_OUT) begin : g_reg
    rr4_out_reg #(.W(OW)) u_oreg (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .d_i  (sum_c),
      .q_o  (sum_o)
    );
  end else begin : g_comb
    assign sum_o = sum_c;
  end
endmodule

// File: rtl/rr4_cfadd_chk.sv
module rr4_cfadd_chk
  import rr4_pkg::*;
#(
  parameter int M            = 8,
  parameter bit REGISTER_OUT = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic [3*M-1:0]     a_i,
  input logic [3*M-1:0]     b_i,
  input logic [3*(M+1)-1:0] sum_o
);
  localparam int OW = 3 * (M + 1);

  function automatic longint wval(input logic [OW-1:0] w);
    longint acc;
    acc = 0;
    for (int k = M; k >= 0; k--) acc = acc * 4 + longint'(rr4_dec(w[3*k +: 3]));
    return acc;
  endfunction

  function automatic bit has_negzero(input logic [OW-1:0] w);
    bit f;
    f = 1'b0;
    for (int k = 0; k <= M; k++) if (w[3*k +: 3] == 3'b100) f = 1'b1;
    return f;
  endfunction

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_no_negzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> !has_negzero(sum_o));

  assert_top_digit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (sum_o[3*M+1] == 1'b0));

  if (REGISTER_OUT) begin : g_reg_chk
    assert_reset_clear_R8: assert property (@(posedge clk)
      !rst_n |-> (sum_o == '0));

    assert_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(en)) |->
        (wval(sum_o) == $past(wval(OW'(a_i)) + wval(OW'(b_i)))));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(en)) |-> $stable(sum_o));
  end else begin : g_comb_chk
    assert_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wval(sum_o) == wval(OW'(a_i)) + wval(OW'(b_i)));
  end
endmodule

bind rr4_cfadd rr4_cfadd_chk #(.M(M), .REGISTER_OUT(REGISTER_OUT)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .en   (en),
  .a_i  (a_i),
  .b_i  (b_i),
  .sum_o(sum_o)
);

// File: tb/tb_rr4_cfadd.sv
`timescale 1ns/1ps
module tb_rr4_cfadd;
  localparam int M  = 8;
  localparam int IW = 3 * M;
  localparam int OW = 3 * (M + 1);

  logic          clk;
  logic          rst_n;
  logic          en;
  logic [IW-1:0] a;
  logic [IW-1:0] b;
  logic [OW-1:0] sum;

  int n_run;
  int n_fail;

  rr4_cfadd #(.M(M), .REGISTER_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .a_i(a), .b_i(b), .sum_o(sum)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // digit code helpers written from R1
  function automatic int dval(input logic [2:0] c);
    return c[2] ? -int'(c[1:0]) : int'(c[1:0]);
  endfunction

  function automatic logic [2:0] dcode(input int v);
    return (v < 0) ? {1'b1, 2'(-v)} : {1'b0, 2'(v)};
  endfunction

  function automatic longint oval(input logic [OW-1:0] w);
    longint acc = 0;
    for (int k = M; k >= 0; k--) acc = acc * 4 + dval(w[3*k +: 3]);
    return acc;
  endfunction

  function automatic longint ival(input logic [IW-1:0] w);
    longint acc = 0;
    for (int k = M - 1; k >= 0; k--) acc = acc * 4 + dval(w[3*k +: 3]);
    return acc;
  endfunction

  function automatic logic [IW-1:0] rnd_word();
    logic [IW-1:0] w;
    for (int k = 0; k < M; k++) w[3*k +: 3] = dcode(int'($urandom_range(6, 0)) - 3);
    return w;
  endfunction

  function automatic logic [IW-1:0] fill(input int v);
    logic [IW-1:0] w;
    for (int k = 0; k < M; k++) w[3*k +: 3] = dcode(v);
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, one rising edge, sample at next negedge
  task automatic apply(input logic [IW-1:0] x, input logic [IW-1:0] y);
    @(negedge clk);
    a = x; b = y; en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(sum == '0, "R8", longint'(sum), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_encoding();
    logic [IW-1:0] x;
    x = '0;
    x[2:0] = 3'b001;
    apply(x, '0);
    check(sum[2:0] == 3'b001, "R1", longint'(sum[2:0]), 1);
    x = '0;
    x[5:3] = 3'b110;
    apply(x, '0);
    check(oval(sum) == -8, "R1", oval(sum), -8);
  endtask

  task automatic t_random();
    for (int n = 0; n < 40; n++) begin
      logic [IW-1:0] x, y;
      bit bad;
      x = rnd_word();
      y = rnd_word();
      apply(x, y);
      check(oval(sum) == ival(x) + ival(y), "R2", oval(sum), ival(x) + ival(y));
      bad = 1'b0;
      for (int k = 0; k <= M; k++) if (sum[3*k +: 3] == 3'b100) bad = 1'b1;
      check(!bad, "R3", longint'(bad), 0);
      check(dval(sum[3*M +: 3]) >= -1 && dval(sum[3*M +: 3]) <= 1, "R5",
            dval(sum[3*M +: 3]), 0);
    end
  endtask

  // every position emits and absorbs a transfer at once
  task automatic t_corners();
    logic [OW-1:0] exp;
    exp = '0;
    for (int k = 1; k < M; k++) exp[3*k +: 3] = 3'b011;
    exp[2:0] = 3'b010;
    exp[3*M +: 3] = 3'b001;
    apply(fill(3), fill(3));
    check(sum == exp, "R9", longint'(sum), longint'(exp));
    check(oval(sum) == 2 * ival(fill(3)), "R2", oval(sum), 2 * ival(fill(3)));
    for (int k = 1; k < M; k++) exp[3*k +: 3] = 3'b111;
    exp[2:0] = 3'b110;
    exp[3*M +: 3] = 3'b101;
    apply(fill(-3), fill(-3));
    check(sum == exp, "R9", longint'(sum), longint'(exp));
    apply(fill(3), fill(-3));
    check(sum == '0, "R9", longint'(sum), 0);
  endtask

  task automatic t_negzero();
    for (int n = 0; n < 6; n++) begin
      logic [IW-1:0] x, xz, y;
      logic [OW-1:0] r0;
      int pos;
      pos = int'($urandom_range(M - 1, 0));
      x = rnd_word();
      y = rnd_word();
      x[3*pos +: 3] = 3'b000;
      xz = x;
      xz[3*pos +: 3] = 3'b100;
      apply(x, y);
      r0 = sum;
      apply(xz, y);
      check(sum == r0, "R4", longint'(sum), longint'(r0));
    end
  endtask

  task automatic t_locality();
    for (int n = 0; n < 8; n++) begin
      logic [IW-1:0] x, x2, y;
      logic [OW-1:0] r0, mask;
      int j;
      j = int'($urandom_range(M - 1, 0));
      x = rnd_word();
      y = rnd_word();
      x2 = x;
      x2[3*j +: 3] = dcode(int'($urandom_range(6, 0)) - 3);
      apply(x, y);
      r0 = sum;
      apply(x2, y);
      mask = '1;
      mask[3*j +: 6] = '0;
      check((sum & mask) == (r0 & mask), "R6", longint'(sum & mask), longint'(r0 & mask));
    end
  endtask

  task automatic t_enable();
    logic [IW-1:0] x, y;
    logic [OW-1:0] held;
    x = fill(1);
    y = fill(2);
    apply(x, y);
    held = sum;
    @(negedge clk);
    en = 1'b0;
    a = fill(-2);
    b = fill(-1);
    @(negedge clk);
    @(negedge clk);
    check(sum == held, "R7", longint'(sum), longint'(held));
    en = 1'b1;
    @(negedge clk);
    check(oval(sum) == ival(fill(-2)) + ival(fill(-1)), "R7", oval(sum),
          ival(fill(-2)) + ival(fill(-1)));
  endtask

  initial begin
    #2_000_000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0;
    n_fail = 0;
    rst_n = 1'b0;
    en = 1'b0;
    a = '0;
    b = '0;
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_encoding();
    t_corners();
    t_random();
    t_negzero();
    t_locality();
    t_enable();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule